// File: doc/BRIEF.md
# Time-Base and Watchdog Interrupt Generator

This block turns the system clock of a display controller into a slow periodic
interrupt. A fixed prescaler first brings a 256 kHz source down to a 32 kHz
step rate; a 32.768 kHz crystal source skips the prescaler. A programmable
power-of-two divider follows. It feeds an 8-bit time-base counter, whose top
bit gives a square wave of 1 Hz to 128 Hz. A 2-bit extension counts wraps of
the time-base counter and raises a sticky watchdog time-out flag after four of
them, which is 4 s down to 1/32 s.

The host controls the block through single-cycle commands from a decoder
upstream. One command starts or stops the shared counter. Others pick the
source shown on the interrupt pin, clear the counter or the watchdog, gate the
pin, and set the rate. The interrupt pin is open-drain and active low. It is
modelled as a driver-enable and a pull-low signal.

Top module: `tbw_timebase_wdt`

## Requirements
- R1: After reset the pin driver is off (`irq_oe`=0, `irq_low`=0), the counter is stopped and cleared, no source is routed to the pin, and the rate code is 7.
- R2: With `clk_src`=0 (crystal) the prescaler is bypassed and every active clock is a step input. With `clk_src`=1 (RC) or 2/3 (external), one step input arrives every 8 active clocks.
- R3: Rate code c (`cmd_arg` of the FREQ command) makes the time-base counter advance once every 2^(7-c) step inputs.
- R4: TIMER_EN starts counting and routes the time base to the pin. The pin is pulled low while the counter's top bit is 0 (phases 0 to 127) and released for phases 128 to 255.
- R5: WDT_EN starts counting and routes the watchdog flag to the pin. The flag sets on the fourth wrap of the time-base counter after a watchdog clear, i.e. after 1024 time-base steps.
- R6: Once set, the flag keeps the pin low until CLR_WDT or IRQ_DIS. IRQ_DIS turns the driver off and drops the flag; IRQ_EN turns the driver on.
- R7: CLR_WDT zeroes the prescaler, the divider, the time-base counter and the watchdog stage. CLR_TIMER zeroes the first three and keeps the watchdog stage.
- R8: WDT_DIS stops the shared counter, which freezes the time-base phase. TIMER_DIS detaches the time base from the pin, so the pin is released.
- R9: TIMER_EN detaches a set watchdog flag from the pin; the pin then follows the time-base phase.
- R10: With `sys_en`=0 the counter holds for the crystal and RC sources. It keeps running for the external source.
- R11: `irq_low` is never high while `irq_oe` is low.
- R12: `cmd_op` codes: 1 TIMER_DIS, 2 WDT_DIS, 3 TIMER_EN, 4 WDT_EN, 5 CLR_TIMER, 6 CLR_WDT, 7 IRQ_DIS, 8 IRQ_EN, 9 FREQ. Codes 0 and 10 to 15 have no effect, and an op has no effect unless `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_src | input | 2 | Clock source: 0 crystal, 1 RC, 2 or 3 external |
| sys_en | input | 1 | System oscillator enabled |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 4 | Command code |
| cmd_arg | input | 3 | Rate code for FREQ |
| irq_oe | output | 1 | Interrupt pin driver enabled |
| irq_low | output | 1 | Interrupt pin pulled low |

## Verification
The hardest state to reach is a watchdog stage that is partly advanced, with a
time-base counter cleared underneath it. Only a long run brings it about, and
the point where the clear lands decides when the flag appears. The stimulus
uses the crystal source at the fastest rate, so that one time-base step is one
clock. It issues CLR_TIMER exactly 900 cycles after WDT_EN, when three wraps
have already been counted. The flag must then appear 256 cycles later, not
1024. The slowest rate code is run once, for one half-period, so that the full
divider width is exercised.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_TIMER_DIS = 4'd1,
        OP_WDT_DIS   = 4'd2,
        OP_TIMER_EN  = 4'd3,
        OP_WDT_EN    = 4'd4,
        OP_CLR_TIMER = 4'd5,
        OP_CLR_WDT   = 4'd6,
        OP_IRQ_DIS   = 4'd7,
        OP_IRQ_EN    = 4'd8,
        OP_FREQ      = 4'd9
    } tbw_op_e;

    typedef enum logic [1:0] {
        IRQ_NONE     = 2'd0,
        IRQ_FROM_TB  = 2'd1,
        IRQ_FROM_WDT = 2'd2
    } tbw_irq_src_e;

    localparam logic [1:0] CLKSRC_XTAL = 2'd0;
    localparam logic [1:0] CLKSRC_RC   = 2'd1;

endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
    import tbw_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [SEL_W-1:0] cmd_arg,
    input  logic [1:0]       clk_src,
    input  logic             sys_en,
    output logic             count_active,
    output logic             src_bypass,
    output tbw_irq_src_e     irq_src,
    output logic             irq_en,
    output logic [SEL_W-1:0] freq_sel,
    output logic             clr_base,
    output logic             clr_wdt,
    output logic             flag_drop
);

    typedef struct packed {
        logic             run;
        tbw_irq_src_e     src;
        logic             irq_en;
        logic [SEL_W-1:0] freq;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{run: 1'b0, src: IRQ_NONE, irq_en: 1'b0,
                                   freq: {SEL_W{1'b1}}};

    ctrl_t   ctrl_d, ctrl_q;
    tbw_op_e op;
    logic    ext_src;

    always_comb begin
        ctrl_d    = ctrl_q;
        op        = tbw_op_e'(cmd_op);
        clr_base  = 1'b0;
        clr_wdt   = 1'b0;
        flag_drop = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_TIMER_DIS: begin
                    if (ctrl_q.src == IRQ_FROM_TB) ctrl_d.src = IRQ_NONE;
                end
                OP_WDT_DIS: begin
                    ctrl_d.run = 1'b0;
                    if (ctrl_q.src == IRQ_FROM_WDT) ctrl_d.src = IRQ_NONE;
                end
                OP_TIMER_EN: begin
                    ctrl_d.run = 1'b1;
                    ctrl_d.src = IRQ_FROM_TB;
                end
                OP_WDT_EN: begin
                    ctrl_d.run = 1'b1;
                    ctrl_d.src = IRQ_FROM_WDT;
                end
                OP_CLR_TIMER: clr_base = 1'b1;
                OP_CLR_WDT: begin
                    clr_base = 1'b1;
                    clr_wdt  = 1'b1;
                end
                OP_IRQ_DIS: begin
                    ctrl_d.irq_en = 1'b0;
                    flag_drop     = 1'b1;
                end
                OP_IRQ_EN: ctrl_d.irq_en = 1'b1;
                OP_FREQ:   ctrl_d.freq   = cmd_arg;
                default: ;
            endcase
        end
        ext_src      = clk_src[1];
        count_active = ctrl_q.run && (sys_en || ext_src);
        src_bypass   = (clk_src == CLKSRC_XTAL);
        irq_src      = ctrl_q.src;
        irq_en       = ctrl_q.irq_en;
        freq_sel     = ctrl_q.freq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/tbw_prescale.sv
module tbw_prescale #(
    parameter int PRE_W = 3,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             bypass,
    input  logic             clr,
    input  logic [SEL_W-1:0] freq_sel,
    output logic             stage
);

    localparam int DIV_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } pre_t;

    pre_t             pre_d, pre_q;
    logic             tick;
    logic [DIV_W-1:0] mask;

    always_comb begin
        pre_d = pre_q;
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i + int'(freq_sel)) < DIV_W;
        end
        tick  = active && (bypass || (&pre_q.pre));
        stage = tick && ((pre_q.div & mask) == mask);
        if (active) pre_d.pre = pre_q.pre + 1'b1;
        if (tick)   pre_d.div = pre_q.div + 1'b1;
        if (clr) begin
            pre_d.pre = '0;
            pre_d.div = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R10: an idle chain keeps its position
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !clr) |=> $stable(pre_q));

endmodule

// File: rtl/tbw_count.sv
module tbw_count #(
    parameter int TB_W  = 8,
    parameter int WDT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stage,
    input  logic clr_base,
    input  logic clr_wdt,
    input  logic flag_drop,
    output logic tb_hi,
    output logic wdt_flag
);

    typedef struct packed {
        logic [TB_W-1:0]  tb;
        logic [WDT_W-1:0] wdt;
        logic             flag;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (stage) begin
            cnt_d.tb = cnt_q.tb + 1'b1;
            if (&cnt_q.tb) begin
                cnt_d.wdt = cnt_q.wdt + 1'b1;
                if (&cnt_q.wdt) cnt_d.flag = 1'b1;
            end
        end
        if (clr_base) cnt_d.tb = '0;
        if (clr_wdt) begin
            cnt_d.wdt  = '0;
            cnt_d.flag = 1'b0;
        end
        if (flag_drop) cnt_d.flag = 1'b0;
        tb_hi    = cnt_q.tb[TB_W-1];
        wdt_flag = cnt_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: the flag only appears as both counters roll over together
    p_flag_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_q.flag) |-> (cnt_q.tb == '0 && cnt_q.wdt == '0));

    // R6: the flag persists until a clear or an interrupt disable
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.flag && !clr_wdt && !flag_drop) |=> cnt_q.flag);

endmodule

// File: rtl/tbw_irq.sv
module tbw_irq
    import tbw_pkg::*;
(
    input  logic         irq_en,
    input  tbw_irq_src_e irq_src,
    input  logic         tb_hi,
    input  logic         wdt_flag,
    output logic         irq_oe,
    output logic         irq_low
);

    logic want_low;

    always_comb begin
        case (irq_src)
            IRQ_FROM_TB:  want_low = !tb_hi;
            IRQ_FROM_WDT: want_low = wdt_flag;
            default:      want_low = 1'b0;
        endcase
        irq_oe  = irq_en;
        irq_low = irq_en && want_low;
    end

endmodule

// File: rtl/tbw_timebase_wdt.sv
module tbw_timebase_wdt
    import tbw_pkg::*;
#(
    parameter int PRE_W = 3,
    parameter int SEL_W = 3,
    parameter int TB_W  = 8,
    parameter int WDT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_src,
    input  logic             sys_en,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [SEL_W-1:0] cmd_arg,
    output logic             irq_oe,
    output logic             irq_low
);

    logic             count_active;
    logic             src_bypass;
    tbw_irq_src_e     irq_src;
    logic             irq_en;
    logic [SEL_W-1:0] freq_sel;
    logic             clr_base;
    logic             clr_wdt;
    logic             flag_drop;
    logic             stage;
    logic             tb_hi;
    logic             wdt_flag;

    tbw_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_arg      (cmd_arg),
        .clk_src      (clk_src),
        .sys_en       (sys_en),
        .count_active (count_active),
        .src_bypass   (src_bypass),
        .irq_src      (irq_src),
        .irq_en       (irq_en),
        .freq_sel     (freq_sel),
        .clr_base     (clr_base),
        .clr_wdt      (clr_wdt),
        .flag_drop    (flag_drop)
    );

    tbw_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (count_active),
        .bypass   (src_bypass),
        .clr      (clr_base),
        .freq_sel (freq_sel),
        .stage    (stage)
    );

    tbw_count #(.TB_W(TB_W), .WDT_W(WDT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .stage     (stage),
        .clr_base  (clr_base),
        .clr_wdt   (clr_wdt),
        .flag_drop (flag_drop),
        .tb_hi     (tb_hi),
        .wdt_flag  (wdt_flag)
    );

    tbw_irq u_irq (
        .irq_en   (irq_en),
        .irq_src  (irq_src),
        .tb_hi    (tb_hi),
        .wdt_flag (wdt_flag),
        .irq_oe   (irq_oe),
        .irq_low  (irq_low)
    );

    // R6: disabling the interrupt floats the pin on the next cycle
    p_dis_floats_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_IRQ_DIS) |=> (!irq_oe && !irq_low));

    // R7: clearing the watchdog releases a pin that shows the watchdog
    p_clr_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_CLR_WDT && irq_src == IRQ_FROM_WDT)
        |=> !irq_low);

endmodule

// File: tb/tbw_timebase_wdt_bench.sv
`timescale 1ns/1ps
module tbw_timebase_wdt_bench;
    import tbw_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_src = 2'd0;
    logic       sys_en = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic [2:0] cmd_arg = 3'd0;
    logic       irq_oe;
    logic       irq_low;

    int  total = 0;
    int  bad   = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    tbw_timebase_wdt u_tbw_timebase_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_src   (clk_src),
        .sys_en    (sys_en),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .irq_oe    (irq_oe),
        .irq_low   (irq_low)
    );

    task automatic chk(input string req, input logic exp_oe, input logic exp_low);
        total++;
        if (irq_oe !== exp_oe || irq_low !== exp_low) begin
            bad++;
            $display("FAIL %s: oe,low=%b%b expected %b%b at %0t",
                     req, irq_oe, irq_low, exp_oe, exp_low, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; the command is taken at the next posedge.
    task automatic issue(input logic [3:0] op, input logic [2:0] arg = 3'd0);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 4'd0;
        cmd_arg   = 3'd0;
    endtask

    task automatic prep(input logic [1:0] src, input logic [2:0] code);
        clk_src = src;
        issue(OP_TIMER_DIS);
        issue(OP_WDT_DIS);
        issue(OP_CLR_WDT);
        issue(OP_FREQ, code);
        issue(OP_IRQ_EN);
    endtask

    task automatic t_reset_default;
        chk("R1 reset pin off", 1'b0, 1'b0);
        clk_src = 2'd0;
        issue(OP_IRQ_EN);
        chk("R1 no source routed", 1'b1, 1'b0);
        issue(OP_TIMER_EN);
        chk("R1 counter cleared at reset", 1'b1, 1'b1);
        step(127);
        chk("R1 default rate phase 127", 1'b1, 1'b1);
        step(1);
        chk("R1 default rate phase 128", 1'b1, 1'b0);
    endtask

    task automatic t_square;
        prep(2'd0, 3'd7);
        issue(OP_TIMER_EN);
        chk("R4 phase 0 low", 1'b1, 1'b1);
        step(127);
        chk("R4 phase 127 low", 1'b1, 1'b1);
        step(1);
        chk("R4 phase 128 released", 1'b1, 1'b0);
        step(127);
        chk("R4 phase 255 released", 1'b1, 1'b0);
        step(1);
        chk("R4 wrap low again", 1'b1, 1'b1);
    endtask

    task automatic t_prescale;
        prep(2'd1, 3'd7);
        issue(OP_TIMER_EN);
        step(1023);
        chk("R2 RC source /8 before", 1'b1, 1'b1);
        step(1);
        chk("R2 RC source /8 edge", 1'b1, 1'b0);
    endtask

    task automatic t_freq;
        prep(2'd0, 3'd6);
        issue(OP_TIMER_EN);
        step(255);
        chk("R3 code 6 before", 1'b1, 1'b1);
        step(1);
        chk("R3 code 6 edge", 1'b1, 1'b0);
        prep(2'd0, 3'd0);
        issue(OP_TIMER_EN);
        step(16383);
        chk("R3 code 0 before", 1'b1, 1'b1);
        step(1);
        chk("R3 code 0 edge", 1'b1, 1'b0);
    endtask

    task automatic t_sys_off;
        sys_en = 1'b0;
        prep(2'd2, 3'd7);
        issue(OP_TIMER_EN);
        step(1023);
        chk("R10 external runs when off, before", 1'b1, 1'b1);
        step(1);
        chk("R10 external runs when off, edge", 1'b1, 1'b0);
        prep(2'd1, 3'd7);
        issue(OP_TIMER_EN);
        step(1100);
        chk("R10 RC held when off", 1'b1, 1'b1);
        prep(2'd0, 3'd7);
        issue(OP_TIMER_EN);
        step(300);
        chk("R10 crystal held when off", 1'b1, 1'b1);
        sys_en = 1'b1;
    endtask

    task automatic t_wdt;
        prep(2'd0, 3'd7);
        issue(OP_WDT_EN);
        chk("R5 flag clear at start", 1'b1, 1'b0);
        step(1023);
        chk("R5 no time-out before 1024", 1'b1, 1'b0);
        step(1);
        chk("R5 time-out at 1024", 1'b1, 1'b1);
        step(50);
        chk("R6 flag holds pin low", 1'b1, 1'b1);
        issue(OP_CLR_WDT);
        chk("R6 clear wdt releases", 1'b1, 1'b0);
        step(1023);
        chk("R7 clear wdt restarts, before", 1'b1, 1'b0);
        step(1);
        chk("R7 clear wdt restarts, edge", 1'b1, 1'b1);
        issue(OP_IRQ_DIS);
        chk("R11 disabled pin floats", 1'b0, 1'b0);
        issue(OP_IRQ_EN);
        chk("R6 irq disable dropped flag", 1'b1, 1'b0);
    endtask

    task automatic t_clr_timer;
        prep(2'd0, 3'd7);
        issue(OP_WDT_EN);
        step(899);
        issue(OP_CLR_TIMER);
        chk("R7 clear timer no flag yet", 1'b1, 1'b0);
        step(255);
        chk("R7 wdt stage kept, before", 1'b1, 1'b0);
        step(1);
        chk("R7 wdt stage kept, edge", 1'b1, 1'b1);
    endtask

    task automatic t_timer_en_detach;
        prep(2'd0, 3'd7);
        issue(OP_WDT_EN);
        step(1024);
        chk("R9 flag set", 1'b1, 1'b1);
        issue(OP_TIMER_EN);
        chk("R9 phase 1 low", 1'b1, 1'b1);
        step(126);
        chk("R9 phase 127 low", 1'b1, 1'b1);
        step(1);
        chk("R9 flag detached", 1'b1, 1'b0);
    endtask

    task automatic t_disables;
        prep(2'd0, 3'd7);
        issue(OP_TIMER_EN);
        step(10);
        issue(OP_WDT_DIS);
        chk("R8 wdt disable phase kept", 1'b1, 1'b1);
        step(300);
        chk("R8 wdt disable stops counter", 1'b1, 1'b1);
        prep(2'd0, 3'd7);
        issue(OP_TIMER_EN);
        chk("R8 timer on", 1'b1, 1'b1);
        issue(OP_TIMER_DIS);
        chk("R8 timer disable releases", 1'b1, 1'b0);
        step(300);
        chk("R8 timer stays detached", 1'b1, 1'b0);
    endtask

    task automatic t_unknown;
        prep(2'd0, 3'd7);
        issue(OP_TIMER_EN);
        step(5);
        issue(4'd15, 3'd0);
        chk("R12 code 15 ignored", 1'b1, 1'b1);
        cmd_op  = OP_IRQ_DIS;
        cmd_arg = 3'd0;
        step(1);
        cmd_op  = 4'd0;
        chk("R12 op without valid ignored", 1'b1, 1'b1);
        step(120);
        chk("R12 phase 127 low", 1'b1, 1'b1);
        step(1);
        chk("R12 phase 128 released", 1'b1, 1'b0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset_default();
        t_square();
        t_prescale();
        t_freq();
        t_sys_off();
        t_wdt();
        t_clr_timer();
        t_timer_en_detach();
        t_disables();
        t_unknown();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule